// File: doc/BRIEF.md
# Bit-Matrix Multiply-Accumulate Unit

This unit is a vector datapath. It multiplies 16x16 single-bit matrices and merges the product into an accumulator matrix. Each 256-bit lane of the operand vectors A, B and C carries one matrix. The unit forms every row-by-column dot product of A and B with AND terms. It reduces each dot product with either OR (a Boolean-semiring product) or XOR (a product over GF(2)), chosen by a one-bit mode input. The reduction is seeded with the matching bit of C, so the product is ORed or XORed into C.

A parameter sets the vector width. The 256-bit form carries one lane. The 512-bit form carries two lanes, and each lane is computed on its own. One register stage holds the result. The result and its valid flag appear one clock after the operands are presented with `valid_in`. There is no per-element write masking: every result bit is written on every accepted operation.

Top module: `bitmat_mac`

## Requirements
- R1: In every lane, matrix element (row i, column j) sits at bit 16*i + j of the lane's 256 bits, for operands and result alike. With B equal to the identity matrix and C zero, the result equals A in both modes.
- R2: With `mode_xor` = 0, result bit (i,j) is C(i,j) OR the OR over k of (A(i,k) AND B(k,j)), so every bit set in C stays set in the result.
- R3: With `mode_xor` = 1, result bit (i,j) is C(i,j) XOR the XOR over k of (A(i,k) AND B(k,j)). With A and B both the identity and C zero, the result is the identity.
- R4: With NUM_LANES = 2, lane 0 uses bits [255:0] and lane 1 uses bits [511:256] of each vector. Neither lane's result depends on the other lane's operands. NUM_LANES = 1 gives a single 256-bit lane.
- R5: `valid_out` and the result appear exactly one clock after a cycle with `valid_in` high, and operations presented back to back return back to back. `valid_out` is low one clock after a cycle with `valid_in` low.
- R6: A synchronous active-high `rst` clears `valid_out` at the next clock edge, even when `valid_in` is high in that cycle. The result register is not reset.
- R7: The result holds its value through any cycle with `valid_in` low, whatever the operand and mode inputs carry.
- R8: When A is all zeros, the result equals C in both modes. In OR mode, when C is all ones, the result is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the valid flag |
| valid_in | input | 1 | Operands and mode are present and accepted this cycle |
| mode_xor | input | 1 | Reduction select: 0 = OR, 1 = XOR |
| opa | input | 256*NUM_LANES | Left matrix operand, one matrix per lane |
| opb | input | 256*NUM_LANES | Right matrix operand, one matrix per lane |
| opc | input | 256*NUM_LANES | Accumulator matrix, one per lane |
| valid_out | output | 1 | Result is valid this cycle |
| result | output | 256*NUM_LANES | Accumulated product, one matrix per lane |

## Verification
The hardest thing to reach from the ports is a lane mix-up: a swapped lane base or a transposed index that corrupts only some elements. Identity and all-ones operands cannot expose it, because they are symmetric. The stimulus therefore loads different random data into the two lanes, in both modes and back to back. It also runs a case with one lane zeroed and the other lane random. A triple-loop model in the bench predicts every bit. A second hard case is a reset that arrives together with a valid operation. The bench drives exactly that and then checks that no result is flagged.

// File: rtl/bmx_pkg.sv
package bmx_pkg;
  localparam int MAT_DIM   = 16;
  localparam int LANE_BITS = MAT_DIM * MAT_DIM;

  typedef enum logic {
    RED_OR  = 1'b0,
    RED_XOR = 1'b1
  } red_mode_e;

  // Reduction of one row-by-column product.
  function automatic logic bmx_dot(input logic [MAT_DIM-1:0] arow,
                                   input logic [MAT_DIM-1:0] bcol,
                                   input red_mode_e m);
    logic [MAT_DIM-1:0] prod;
    prod = arow & bcol;
    if (m == RED_XOR) return ^prod;
    return |prod;
  endfunction

  // Fold a reduced product into the accumulator bit.
  function automatic logic bmx_merge(input logic acc, input logic dot,
                                     input red_mode_e m);
    if (m == RED_XOR) return acc ^ dot;
    return acc | dot;
  endfunction
endpackage

// File: rtl/bmx_row.sv
module bmx_row
  import bmx_pkg::*;
(
  input  logic [MAT_DIM-1:0]   a_row,
  input  logic [LANE_BITS-1:0] b_mat,
  input  logic [MAT_DIM-1:0]   c_row,
  input  red_mode_e            mode,
  output logic [MAT_DIM-1:0]   r_row
);
  logic [MAT_DIM-1:0] dot_bits;

  always_comb begin
    logic [MAT_DIM-1:0] col;
    col = '0;
    dot_bits = '0;
    r_row = '0;
    for (int j = 0; j < MAT_DIM; j++) begin
      for (int k = 0; k < MAT_DIM; k++) begin
        col[k] = b_mat[MAT_DIM*k + j];
      end
      dot_bits[j] = bmx_dot(a_row, col, mode);
      r_row[j]    = bmx_merge(c_row[j], dot_bits[j], mode);
    end
  end
endmodule

// File: rtl/bmx_lane.sv
module bmx_lane
  import bmx_pkg::*;
(
  input  logic [LANE_BITS-1:0] a_mat,
  input  logic [LANE_BITS-1:0] b_mat,
  input  logic [LANE_BITS-1:0] c_mat,
  input  red_mode_e            mode,
  output logic [LANE_BITS-1:0] r_mat
);
  for (genvar i = 0; i < MAT_DIM; i++) begin : g_row
    bmx_row u_row (
      .a_row (a_mat[MAT_DIM*i +: MAT_DIM]),
      .b_mat (b_mat),
      .c_row (c_mat[MAT_DIM*i +: MAT_DIM]),
      .mode  (mode),
      .r_row (r_mat[MAT_DIM*i +: MAT_DIM])
    );
  end
endmodule

// File: rtl/bitmat_mac.sv
module bitmat_mac
  import bmx_pkg::*;
#(
  parameter int NUM_LANES = 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           valid_in,
  input  logic                           mode_xor,
  input  logic [LANE_BITS*NUM_LANES-1:0] opa,
  input  logic [LANE_BITS*NUM_LANES-1:0] opb,
  input  logic [LANE_BITS*NUM_LANES-1:0] opc,
  output logic                           valid_out,
  output logic [LANE_BITS*NUM_LANES-1:0] result
);
  localparam int VEC_W = LANE_BITS * NUM_LANES;

  red_mode_e        sel_mode;
  logic [VEC_W-1:0] lane_sum;
  logic             accept;

  assign sel_mode = red_mode_e'(mode_xor);
  assign accept   = valid_in;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    bmx_lane u_lane (
      .a_mat (opa[LANE_BITS*l +: LANE_BITS]),
      .b_mat (opb[LANE_BITS*l +: LANE_BITS]),
      .c_mat (opc[LANE_BITS*l +: LANE_BITS]),
      .mode  (sel_mode),
      .r_mat (lane_sum[LANE_BITS*l +: LANE_BITS])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) valid_out <= 1'b0;
    else     valid_out <= accept;
  end

  always_ff @(posedge clk) begin
    if (accept) result <= lane_sum;
  end

  // R5: an accepted operation is flagged on the next edge
  assert_valid_next_R5: assert property (@(posedge clk) disable iff (rst)
    valid_in |=> valid_out);
  // R5: idle cycle gives no flag
  assert_valid_idle_R5: assert property (@(posedge clk) disable iff (rst)
    !valid_in |=> !valid_out);
  // R6: reset wins over a simultaneous valid
  assert_reset_clear_R6: assert property (@(posedge clk)
    rst |=> !valid_out);
  // R7: result is held while idle
  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !valid_in |=> $stable(result));
  // R2: OR mode never clears an accumulator bit
  assert_or_keeps_c_R2: assert property (@(posedge clk) disable iff (rst)
    (valid_in && !mode_xor) |=> ((result & $past(opc)) == $past(opc)));
  // R8: a zero left operand returns the accumulator
  assert_zero_a_R8: assert property (@(posedge clk) disable iff (rst)
    (valid_in && (opa == '0)) |=> (result == $past(opc)));
endmodule

// File: tb/test_bitmat_mac.sv
`timescale 1ns/1ps
module test_bitmat_mac;
  localparam int NL = 2;
  localparam int VW = 256 * NL;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          valid_in = 1'b0;
  logic          mode_xor = 1'b0;
  logic [VW-1:0] opa = '0, opb = '0, opc = '0;
  logic          valid_out;
  logic [VW-1:0] result;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  logic [VW-1:0] exp_q[$];
  string         tag_q[$];
  int            cyc_q[$];

  bitmat_mac #(.NUM_LANES(NL)) i_bitmat_mac (
    .clk(clk), .rst(rst), .valid_in(valid_in), .mode_xor(mode_xor),
    .opa(opa), .opb(opb), .opc(opc), .valid_out(valid_out), .result(result)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Reference: per lane, per output element, walk k in order.
  function automatic logic [VW-1:0] model(input logic [VW-1:0] a, b, c, input logic m);
    logic [VW-1:0] r;
    r = '0;
    for (int l = 0; l < NL; l++)
      for (int i = 0; i < 16; i++)
        for (int j = 0; j < 16; j++) begin
          logic acc;
          acc = c[256*l + 16*i + j];
          for (int k = 0; k < 16; k++) begin
            logic t;
            t = a[256*l + 16*i + k] & b[256*l + 16*k + j];
            acc = m ? (acc ^ t) : (acc | t);
          end
          r[256*l + 16*i + j] = acc;
        end
    return r;
  endfunction

  function automatic logic [VW-1:0] rnd();
    logic [VW-1:0] v;
    for (int w = 0; w < VW/32; w++) v[32*w +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [VW-1:0] ident();
    logic [VW-1:0] v;
    v = '0;
    for (int l = 0; l < NL; l++)
      for (int i = 0; i < 16; i++) v[256*l + 17*i] = 1'b1;
    return v;
  endfunction

  task automatic check(input string tag, input logic [VW-1:0] act, exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [VW-1:0] a, b, c, input logic m,
                       input logic [VW-1:0] exp, input string tag);
    @(negedge clk);
    opa = a; opb = b; opc = c; mode_xor = m; valid_in = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag); cyc_q.push_back(cyc);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid_in = 1'b0;
    end
  endtask

  // Monitor: pop and compare each flagged result; latency is R5.
  always @(negedge clk) begin
    if (!rst && valid_out) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R5 actual=valid_out=1 expected=no pending item");
      end else begin
        logic [VW-1:0] e;
        string t;
        int c0;
        e = exp_q.pop_front(); t = tag_q.pop_front(); c0 = cyc_q.pop_front();
        check(t, result, e);
        total++;
        if (cyc != c0 + 1) begin
          bad++;
          $display("FAIL R5 actual=latency %0d expected=1", cyc - c0);
        end
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [VW-1:0] a, b, c, hold;
    repeat (3) @(negedge clk);
    total++;
    if (valid_out !== 1'b0) begin
      bad++; $display("FAIL R6 actual=%b expected=0", valid_out);
    end
    rst = 1'b0;

    // R1: identity B, zero C returns A in both modes
    a = rnd();
    drive(a, ident(), '0, 1'b0, a, "R1 identity OR");
    a = rnd();
    drive(a, ident(), '0, 1'b1, a, "R1 identity XOR");
    // R8: all-ones C in OR mode
    drive(rnd(), rnd(), '1, 1'b0, '1, "R8 ones C");
    // R3: identity squared in XOR mode
    drive(ident(), ident(), '0, 1'b1, ident(), "R3 identity squared");
    // R8: zero A returns C in both modes
    c = rnd();
    drive('0, rnd(), c, 1'b0, c, "R8 zero A OR");
    c = rnd();
    drive('0, rnd(), c, 1'b1, c, "R8 zero A XOR");
    idle(2);

    // R2 / R3 / R4: random, lanes differ, back to back (R5)
    for (int n = 0; n < 24; n++) begin
      logic m;
      a = rnd(); b = rnd(); c = rnd() & rnd();
      m = n[0];
      drive(a, b, c, m, model(a, b, c, m), m ? "R3 random XOR" : "R2 random OR");
    end
    // sparse operands make OR reductions non-trivial
    for (int n = 0; n < 8; n++) begin
      a = rnd() & rnd() & rnd(); b = rnd() & rnd() & rnd(); c = '0;
      drive(a, b, c, 1'b0, model(a, b, c, 1'b0), "R2 sparse OR");
    end
    // R4: lane 0 zero operands, lane 1 random: lane 0 must stay zero
    a = rnd(); b = rnd(); c = rnd();
    a[255:0] = '0; b[255:0] = '0; c[255:0] = '0;
    drive(a, b, c, 1'b1, model(a, b, c, 1'b1), "R4 lane isolation");
    a = rnd(); b = rnd(); c = '0;
    a[511:256] = '0;
    drive(a, b, c, 1'b1, model(a, b, c, 1'b1), "R4 lane isolation hi");
    idle(3);

    // R7: hold while idle with changing inputs
    hold = result;
    for (int n = 0; n < 4; n++) begin
      @(negedge clk);
      opa = rnd(); opb = rnd(); opc = rnd(); mode_xor = n[0]; valid_in = 1'b0;
    end
    @(negedge clk);
    check("R7 hold", result, hold);
    total++;
    if (valid_out !== 1'b0) begin
      bad++; $display("FAIL R5 actual=%b expected=0", valid_out);
    end

    // R6: reset together with a valid operation
    @(negedge clk);
    rst = 1'b1; valid_in = 1'b1; opa = rnd();
    @(negedge clk);
    total++;
    if (valid_out !== 1'b0) begin
      bad++; $display("FAIL R6 actual=%b expected=0", valid_out);
    end
    rst = 1'b0; valid_in = 1'b0;
    idle(2);

    a = rnd(); b = rnd(); c = rnd();
    drive(a, b, c, 1'b1, model(a, b, c, 1'b1), "R6 after reset");
    idle(4);

    total++;
    if (exp_q.size() != 0) begin
      bad++; $display("FAIL R5 actual=%0d pending expected=0", exp_q.size());
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule